// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

This block gathers every reset source of a small controller core (power-on, an external active-low master-clear pin, a watchdog time-out pulse and a supply-edge detector trip) into one core reset. After the last active source goes away, the core stays in reset for an oscillator start-up delay. The delay is picked by an option code and measured in ticks of an external timing strobe. The clock type sets a floor on that code, because crystal oscillators need the longer delays.

Two status flags record why the core was last reset: a time-out flag and a power-loss flag. Their new values depend on the source and on whether the core was asleep when the reset arrived. The core's watchdog-clear and sleep instructions also write these flags. The block also presents the reset values for the port-direction registers (every pin an input) and for the three upper status bits.

Top module: `reset_cause_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o`=1, `tf_o`=1 and `pf_o`=1. After `por_i` falls, the first clock edge loads the start-up delay, and `core_rst_o` stays high for that delay.
- R2: The delay, counted in `tick_i` pulses, is set by the effective code: 0 gives 1 tick, 1 gives 133, 2 gives 267 and 3 gives 533. With one tick every cycle, `core_rst_o` stays high for exactly that many cycles after the edge that sampled the last active source.
- R3: `osc_kind_i` encodes 0 = RC, 1 = high-frequency crystal, 2 = standard crystal, 3 = low-frequency crystal. For codes 1 and 2 the effective delay code is at least 1. For code 3 it is at least 2. For RC, `dly_sel_i` is used as given.
- R4: `mclr_n_i` is active low and passes through a two-flop synchronizer. Reset is held while it is low and for the start-up delay after it rises.
- R5: A master-clear assertion outside sleep leaves both flags unchanged. During sleep (`sleep_i`=1) it gives `tf_o`=1 and `pf_o`=0.
- R6: A watchdog pulse outside sleep gives `tf_o`=0 and `pf_o`=1. During sleep it gives `tf_o`=0 and `pf_o`=0. Both cases raise `core_rst_o` on the next cycle.
- R7: When `ped_en_i`=1 and `sleep_i`=0, `ped_trip_i` resets the core and gives `tf_o`=1 and `pf_o`=1, taking priority over a simultaneous watchdog pulse. It has no effect when disabled or when sleeping.
- R8: `clrwdt_i` gives `tf_o`=1 and `pf_o`=1. `sleep_cmd_i` gives `tf_o`=1 and `pf_o`=0. Both are ignored while `core_rst_o` is high.
- R9: Overlapping sources restart the delay, so the full delay runs after the last one releases. The count advances only on cycles where `tick_i`=1.
- R10: `dir_init_o` is all ones (1 = input) and `stat_hi_o` is 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, asynchronous, active high |
| mclr_n_i | input | 1 | Raw master-clear pin, active low |
| wdt_to_i | input | 1 | Watchdog time-out pulse, synchronous |
| ped_trip_i | input | 1 | Supply-edge detector trip |
| ped_en_i | input | 1 | Option bit enabling the supply-edge detector |
| sleep_i | input | 1 | Core is sleeping |
| clrwdt_i | input | 1 | Watchdog-clear instruction strobe |
| sleep_cmd_i | input | 1 | Sleep instruction strobe |
| osc_kind_i | input | 2 | Oscillator type option |
| dly_sel_i | input | 2 | Start-up delay option code |
| tick_i | input | 1 | Timing strobe for the delay counter |
| core_rst_o | output | 1 | Core reset, active high |
| tf_o | output | 1 | Time-out flag |
| pf_o | output | 1 | Power-loss flag |
| dir_init_o | output | N_PORTS*PORT_W | Reset value of the port-direction registers |
| stat_hi_o | output | 3 | Reset value of status bits 7..5 |

## Verification
The assertions check on every cycle that an active source raises the core reset on the next cycle, and that the reset only falls after a tick with no source present. They also check the flag values written by each source in each sleep state, and that instruction strobes leave the flags alone while reset is held. Only the bench's scenarios can show the exact length of the start-up delay for each oscillator and option pair, the restart when sources overlap, the counter stall without ticks, and the detector being ignored when disabled or while sleeping.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   typedef enum logic [1:0] {OSC_RC = 2'd0, OSC_HF = 2'd1, OSC_XT = 2'd2, OSC_LF = 2'd3} osc_kind_e;

   // Clamp the requested start-up code to the floor allowed by the oscillator.
   function automatic logic [1:0] eff_code(input logic [1:0] osc, input logic [1:0] code);
      logic [1:0] floor_c;
      case (osc_kind_e'(osc))
         OSC_HF, OSC_XT: floor_c = 2'd1;
         OSC_LF:         floor_c = 2'd2;
         default:        floor_c = 2'd0;
      endcase
      return (code < floor_c) ? floor_c : code;
   endfunction
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic por_i,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) chain <= {STAGES{RST_VAL}};
      else       chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rstc_delay.sv
module rstc_delay #(
   parameter int T0 = 1,
   parameter int T1 = 133,
   parameter int T2 = 267,
   parameter int T3 = 533
) (
   input  logic       clk_i,
   input  logic       por_i,
   input  logic       src_i,
   input  logic       tick_i,
   input  logic [1:0] code_i,
   output logic       busy_o
);
   localparam int TMAX = (T3 > T2) ? ((T3 > T1) ? ((T3 > T0) ? T3 : T0) : ((T1 > T0) ? T1 : T0))
                                   : ((T2 > T1) ? ((T2 > T0) ? T2 : T0) : ((T1 > T0) ? T1 : T0));
   localparam int CW = $clog2(TMAX + 1);

   if (T0 < 1 || T1 < 1 || T2 < 1 || T3 < 1) begin : g_bad_ticks
      $error("rstc_delay: every delay must be at least one tick");
   end

   logic          pend;
   logic          src_all;
   logic [CW-1:0] cnt;
   logic [CW-1:0] load;

   assign src_all = src_i | pend;

   always_comb begin
      case (code_i)
         2'd0:    load = CW'(T0);
         2'd1:    load = CW'(T1);
         2'd2:    load = CW'(T2);
         default: load = CW'(T3);
      endcase
   end

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         pend   <= 1'b1;
         busy_o <= 1'b1;
         cnt    <= '0;
      end else if (src_all) begin
         pend   <= 1'b0;
         busy_o <= 1'b1;
         cnt    <= load;
      end else if (busy_o && tick_i) begin
         if (cnt <= CW'(1)) begin
            busy_o <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt - CW'(1);
         end
      end
   end

   a_r6_src_raises_reset : assert property (@(posedge clk_i) disable iff (por_i)
      src_i |=> busy_o);
   a_r9_release_needs_tick : assert property (@(posedge clk_i) disable iff (por_i)
      $fell(busy_o) |-> $past(tick_i && !src_i));
endmodule

// File: rtl/rstc_flags.sv
module rstc_flags (
   input  logic clk_i,
   input  logic por_i,
   input  logic ped_evt_i,
   input  logic wdt_evt_i,
   input  logic mclr_evt_i,
   input  logic sleep_i,
   input  logic clrwdt_i,
   input  logic slp_cmd_i,
   input  logic busy_i,
   output logic tf_o,
   output logic pf_o
);
   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         tf_o <= 1'b1;
         pf_o <= 1'b1;
      end else if (ped_evt_i) begin
         tf_o <= 1'b1;
         pf_o <= 1'b1;
      end else if (wdt_evt_i) begin
         tf_o <= 1'b0;
         pf_o <= ~sleep_i;
      end else if (mclr_evt_i) begin
         if (sleep_i) begin
            tf_o <= 1'b1;
            pf_o <= 1'b0;
         end
      end else if (!busy_i && clrwdt_i) begin
         tf_o <= 1'b1;
         pf_o <= 1'b1;
      end else if (!busy_i && slp_cmd_i) begin
         tf_o <= 1'b1;
         pf_o <= 1'b0;
      end
   end

   a_r6_wdt_awake : assert property (@(posedge clk_i) disable iff (por_i)
      wdt_evt_i && !ped_evt_i && !sleep_i |=> !tf_o && pf_o);
   a_r6_wdt_asleep : assert property (@(posedge clk_i) disable iff (por_i)
      wdt_evt_i && !ped_evt_i && sleep_i |=> !tf_o && !pf_o);
   a_r5_mclr_asleep : assert property (@(posedge clk_i) disable iff (por_i)
      mclr_evt_i && sleep_i && !wdt_evt_i && !ped_evt_i |=> tf_o && !pf_o);
   a_r5_mclr_awake : assert property (@(posedge clk_i) disable iff (por_i)
      mclr_evt_i && !sleep_i && !wdt_evt_i && !ped_evt_i |=> $stable(tf_o) && $stable(pf_o));
   a_r7_ped_sets : assert property (@(posedge clk_i) disable iff (por_i)
      ped_evt_i |=> tf_o && pf_o);
   a_r8_ignored_in_reset : assert property (@(posedge clk_i) disable iff (por_i)
      busy_i && !ped_evt_i && !wdt_evt_i && !mclr_evt_i |=> $stable(tf_o) && $stable(pf_o));
endmodule

// File: rtl/reset_cause_seq.sv
module reset_cause_seq #(
   parameter int N_PORTS     = 3,
   parameter int PORT_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TICKS_C0    = 1,
   parameter int TICKS_C1    = 133,
   parameter int TICKS_C2    = 267,
   parameter int TICKS_C3    = 533
) (
   input  logic                      clk_i,
   input  logic                      por_i,
   input  logic                      mclr_n_i,
   input  logic                      wdt_to_i,
   input  logic                      ped_trip_i,
   input  logic                      ped_en_i,
   input  logic                      sleep_i,
   input  logic                      clrwdt_i,
   input  logic                      sleep_cmd_i,
   input  logic [1:0]                osc_kind_i,
   input  logic [1:0]                dly_sel_i,
   input  logic                      tick_i,
   output logic                      core_rst_o,
   output logic                      tf_o,
   output logic                      pf_o,
   output logic [N_PORTS*PORT_W-1:0] dir_init_o,
   output logic [2:0]                stat_hi_o
);
   import rstc_pkg::*;

   if (N_PORTS < 1 || PORT_W < 1) begin : g_bad_ports
      $error("reset_cause_seq: N_PORTS and PORT_W must be positive");
   end

   logic mclr_s, mclr_act, mclr_q, mclr_evt, ped_evt, src_any;
   logic [1:0] code_eff;

   rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mclr_sync (
      .clk_i(clk_i), .por_i(por_i), .d_i(mclr_n_i), .q_o(mclr_s));

   assign mclr_act = ~mclr_s;

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) mclr_q <= 1'b0;
      else       mclr_q <= mclr_act;
   end

   assign mclr_evt = mclr_act & ~mclr_q;
   assign ped_evt  = ped_trip_i & ped_en_i & ~sleep_i;
   assign src_any  = mclr_act | wdt_to_i | ped_evt;
   assign code_eff = eff_code(osc_kind_i, dly_sel_i);

   rstc_delay #(.T0(TICKS_C0), .T1(TICKS_C1), .T2(TICKS_C2), .T3(TICKS_C3)) u_delay (
      .clk_i(clk_i), .por_i(por_i), .src_i(src_any), .tick_i(tick_i),
      .code_i(code_eff), .busy_o(core_rst_o));

   rstc_flags u_flags (
      .clk_i(clk_i), .por_i(por_i), .ped_evt_i(ped_evt), .wdt_evt_i(wdt_to_i),
      .mclr_evt_i(mclr_evt), .sleep_i(sleep_i), .clrwdt_i(clrwdt_i),
      .slp_cmd_i(sleep_cmd_i), .busy_i(core_rst_o), .tf_o(tf_o), .pf_o(pf_o));

   for (genvar p = 0; p < N_PORTS; p++) begin : g_dir
      assign dir_init_o[p*PORT_W +: PORT_W] = {PORT_W{1'b1}};
   end

   assign stat_hi_o = 3'b100;

   a_r4_mclr_holds : assert property (@(posedge clk_i) disable iff (por_i)
      mclr_act |=> core_rst_o);
   a_r7_ped_gated : assert property (@(posedge clk_i) disable iff (por_i)
      ped_trip_i && (!ped_en_i || sleep_i) && !mclr_act && !wdt_to_i && !core_rst_o
      |=> $stable(tf_o) && $stable(pf_o));
endmodule

// File: tb/reset_cause_seq_tb.sv
module reset_cause_seq_tb;
   logic clk = 1'b0;
   always #2ns clk = ~clk;

   logic por = 1'b1, mclr_n = 1'b1, wdt = 1'b0, ped = 1'b0, ped_en = 1'b0, slp = 1'b0;
   logic clrwdt = 1'b0, slpcmd = 1'b0, tick = 1'b1;
   logic [1:0] osc = 2'd0, sel = 2'd0;
   logic core_rst, tf, pf;
   logic [23:0] dir_init;
   logic [2:0] stat_hi;

   int total = 0, bad = 0;

   reset_cause_seq u_dut (
      .clk_i(clk), .por_i(por), .mclr_n_i(mclr_n), .wdt_to_i(wdt), .ped_trip_i(ped),
      .ped_en_i(ped_en), .sleep_i(slp), .clrwdt_i(clrwdt), .sleep_cmd_i(slpcmd),
      .osc_kind_i(osc), .dly_sel_i(sel), .tick_i(tick), .core_rst_o(core_rst),
      .tf_o(tf), .pf_o(pf), .dir_init_o(dir_init), .stat_hi_o(stat_hi));

   // {osc, sel, expected ticks} from R2/R3
   localparam logic [13:0] VEC [10] = '{
      {2'd0, 2'd0, 10'd1},   {2'd0, 2'd1, 10'd133}, {2'd0, 2'd2, 10'd267},
      {2'd0, 2'd3, 10'd533}, {2'd1, 2'd0, 10'd133}, {2'd2, 2'd0, 10'd133},
      {2'd2, 2'd2, 10'd267}, {2'd3, 2'd0, 10'd267}, {2'd3, 2'd1, 10'd267},
      {2'd3, 2'd3, 10'd533}};

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1ns;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000 && core_rst; i++) step();
   endtask

   // Counts the cycles core_rst stays high, starting now.
   task automatic count_rst(output int n);
      n = 0;
      while (core_rst && n < 3000) begin
         n++;
         step();
      end
   endtask

   task automatic pulse_wdt();
      wdt = 1'b1;
      step();
      wdt = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      step();
      // R1 / R10: state while power-on is asserted
      check("R1 core_rst in por", core_rst, 1);
      check("R1 tf in por", tf, 1);
      check("R1 pf in por", pf, 1);
      check("R10 dir_init", (dir_init == 24'hFFFFFF), 1);
      check("R10 stat_hi", stat_hi, 3'b100);

      // R1: release with code 2 on RC -> 267 ticks after first edge
      sel = 2'd2;
      por = 1'b0;
      step();
      count_rst(n);
      check("R1 por delay", n, 267);

      // R2 / R3: table walk, each via a watchdog pulse outside sleep (R6)
      foreach (VEC[i]) begin
         osc = VEC[i][13:12];
         sel = VEC[i][11:10];
         step();
         pulse_wdt();
         count_rst(n);
         check("R2_R3 delay", n, int'(VEC[i][9:0]));
         check("R6 wdt awake tf", tf, 0);
         check("R6 wdt awake pf", pf, 1);
      end

      // R5: master clear outside sleep keeps flags (0,1)
      osc = 2'd0; sel = 2'd0;
      mclr_n = 1'b0;
      repeat (5) step();
      check("R4 mclr holds", core_rst, 1);
      mclr_n = 1'b1;
      step();
      check("R4 still held after rise", core_rst, 1);
      wait_idle();
      check("R4 released", core_rst, 0);
      check("R5 mclr awake tf", tf, 0);
      check("R5 mclr awake pf", pf, 1);

      // R5: master clear during sleep -> (1,0)
      slp = 1'b1;
      mclr_n = 1'b0;
      repeat (5) step();
      mclr_n = 1'b1;
      slp = 1'b0;
      wait_idle();
      check("R5 mclr sleep tf", tf, 1);
      check("R5 mclr sleep pf", pf, 0);

      // R6: watchdog during sleep -> (0,0)
      slp = 1'b1;
      pulse_wdt();
      slp = 1'b0;
      check("R6 wdt raises reset", core_rst, 1);
      wait_idle();
      check("R6 wdt sleep tf", tf, 0);
      check("R6 wdt sleep pf", pf, 0);

      // R8: instruction strobes
      clrwdt = 1'b1; step(); clrwdt = 1'b0;
      check("R8 clrwdt tf", tf, 1);
      check("R8 clrwdt pf", pf, 1);
      slpcmd = 1'b1; step(); slpcmd = 1'b0;
      check("R8 sleep cmd tf", tf, 1);
      check("R8 sleep cmd pf", pf, 0);
      sel = 2'd3;
      pulse_wdt();
      clrwdt = 1'b1; step(); clrwdt = 1'b0;
      check("R8 clrwdt ignored tf", tf, 0);
      check("R8 clrwdt ignored pf", pf, 1);
      wait_idle();

      // R7: detector disabled, then enabled but sleeping -> ignored
      ped = 1'b1; ped_en = 1'b0;
      step(); step();
      check("R7 disabled no reset", core_rst, 0);
      check("R7 disabled tf", tf, 0);
      ped_en = 1'b1; slp = 1'b1;
      step(); step();
      check("R7 sleeping no reset", core_rst, 0);
      check("R7 sleeping tf", tf, 0);
      // enabled and awake, with a simultaneous watchdog pulse -> (1,1)
      slp = 1'b0; sel = 2'd0;
      wdt = 1'b1;
      step();
      wdt = 1'b0; ped = 1'b0;
      check("R7 ped resets", core_rst, 1);
      check("R7 ped tf", tf, 1);
      check("R7 ped pf", pf, 1);
      ped_en = 1'b0;
      wait_idle();

      // R9: overlapping sources restart the delay
      sel = 2'd1;
      pulse_wdt();
      repeat (50) step();
      pulse_wdt();
      count_rst(n);
      check("R9 overlap restart", n, 133);

      // R9: no tick -> no progress
      pulse_wdt();
      tick = 1'b0;
      repeat (300) step();
      check("R9 stalled without tick", core_rst, 1);
      tick = 1'b1;
      count_rst(n);
      check("R9 resumes count", n, 133);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule